// File: doc/BRIEF.md
# Cache Tag Array Window

This block is a bus-slave port through which software reaches the tag store of a four-way set-associative cache as if it were ordinary memory. Each 32-bit word in a fixed address window names one way of one cache set. A read returns the stored tag, replacement (LRU) bits, dirty bit and valid bit for that slot. A direct write, one with the associative bit clear, replaces those fields. A parameter picks which window an instance serves: the instruction-cache window at 0xF000_0000 to 0xF07F_FFFF, or the operand-cache window at 0xF080_0000 to 0xF0FF_FFFF. Only the operand-cache variant keeps a dirty bit.

Requests arrive on a valid/ready channel. The port raises `req_ready` only while idle, so it takes at most one request at a time. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. Every accepted request produces exactly one single-cycle `rsp_valid` pulse, and the requester must accept that pulse; there is no ready signal on the response side. In the operand variant, a direct write to a line that is both dirty and valid must have that line written back first. The port raises `wb_req` with the old tag, set and way, and holds those values steady until `wb_ack` is seen high on a clock edge. Until then it gives no response and accepts no new request.

Top module: `tag_window_port`

## Requirements
- R1: An access whose address bits 31:23 differ from this instance's window (0x1E0 for the instruction variant, 0x1E1 for the operand variant) is answered with `rsp_err`=1 and changes no stored entry.
- R2: An access with `req_size` other than 2'b10 (32-bit word; 2'b00 is byte and 2'b01 is half-word), or with address bits 1:0 not 00, is answered with `rsp_err`=1 and changes no stored entry.
- R3: An access with `req_fetch`=1 is answered with `rsp_err`=1 and has no effect.
- R4: The address selects the set with bits 11:4 (256 sets), the way with bits 13:12 (00 is way 0 through 11 is way 3), and carries the associative bit in bit 3.
- R5: A read returns the addressed set and way whatever the associative bit is. The layout is tag in bits 31:10, LRU in bits 9:4, dirty in bit 1 and valid in bit 0, and bits 3:2 read as zero.
- R6: Tag bits 31:29 always read as zero, whatever was written to them.
- R7: A legal write with the associative bit at 0 stores the tag, LRU, dirty and valid fields of `req_wdata` in the selected set and way, and the response has `rsp_err`=0.
- R8: A write that stores valid=0 also stores dirty=0.
- R9: In the instruction variant the dirty bit always reads 0, and no write-back is ever requested.
- R10: In the operand variant, a direct write to a line whose stored dirty and valid bits are both 1 raises `wb_req` with the old tag, set and way held steady. The new fields are stored and the response is given only after `wb_ack` is seen; until then `req_ready` and `rsp_valid` stay low. No other access raises `wb_req`.
- R11: A legal write with the associative bit at 1 changes no stored entry and is answered with `rsp_err`=0.
- R12: After reset every entry reads as zero, `req_ready` is 1, and `rsp_valid` and `wb_req` are 0. Each accepted request yields one `rsp_valid` pulse, one cycle long, two clock edges after acceptance when no write-back is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port idle and able to take a request |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data (tag, LRU, dirty, valid) |
| req_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| req_fetch | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access was rejected |
| wb_req | output | 1 | Write-back of a dirty line requested |
| wb_ack | input | 1 | Write-back finished |
| wb_tag | output | 22 | Tag of the line to write back |
| wb_index | output | 8 | Set of the line to write back |
| wb_way | output | 2 | Way of the line to write back |

## Verification
The hardest state to reach is the stalled direct write. To get there, the bench first has to place a line that is both dirty and valid through the port itself. Before that, it writes the same slot with valid cleared and dirty set, which shows that the dirty bit gets dropped. It then withholds `wb_ack` for several cycles and checks, on each one, that the request fields stay steady and that the bus stays blocked. A second instance of the instruction variant shares the request bus, and the bench uses it to confirm that a dirty-and-valid pattern there never stalls.

// File: rtl/tagwin_pkg.sv
package tagwin_pkg;
  localparam int DATA_W   = 32;
  localparam int TAG_W    = 22;            // visible tag width in the word
  localparam int TAG_KEEP = 19;            // stored tag bits (top three read zero)
  localparam int LRU_W    = 6;
  localparam int TAG_LSB  = 10;
  localparam int LRU_LSB  = 4;
  localparam int U_POS    = 1;
  localparam int V_POS    = 0;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WBWAIT} tw_state_e;

  typedef struct packed {
    logic [TAG_KEEP-1:0] tag;
    logic [LRU_W-1:0]    lru;
    logic                u;
    logic                v;
  } line_t;

  function automatic line_t word_to_line(input logic [DATA_W-1:0] w);
    line_t l;
    l.tag = w[TAG_LSB +: TAG_KEEP];
    l.lru = w[LRU_LSB +: LRU_W];
    l.u   = w[U_POS];
    l.v   = w[V_POS];
    return l;
  endfunction

  function automatic logic [DATA_W-1:0] line_to_word(input line_t l);
    logic [DATA_W-1:0] w;
    w = '0;
    w[TAG_LSB +: TAG_KEEP] = l.tag;
    w[LRU_LSB +: LRU_W]    = l.lru;
    w[U_POS]               = l.u;
    w[V_POS]               = l.v;
    return w;
  endfunction
endpackage

// File: rtl/tagwin_decode.sv
module tagwin_decode
  import tagwin_pkg::*;
#(
  parameter bit OPERAND = 1'b1,
  parameter int IDX_W   = 8,
  parameter int WAY_W   = 2
) (
  input  logic [DATA_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              fetch,
  output logic              bad,
  output logic              assoc,
  output logic [IDX_W-1:0]  idx,
  output logic [WAY_W-1:0]  way
);
  localparam int WIN_LSB  = 23;
  localparam int IDX_LSB  = 4;
  localparam int WAY_LSB  = IDX_LSB + IDX_W;
  localparam int A_POS    = 3;
  localparam logic [DATA_W-1-WIN_LSB:0] WIN_TAG = {8'hF0, OPERAND};

  logic in_win;
  logic unused_mid;

  assign in_win     = (addr[DATA_W-1:WIN_LSB] == WIN_TAG);
  assign bad        = !in_win || (size != SIZE_WORD) || (addr[1:0] != 2'b00) || fetch;
  assign assoc      = addr[A_POS];
  assign idx        = addr[IDX_LSB +: IDX_W];
  assign way        = addr[WAY_LSB +: WAY_W];
  assign unused_mid = ^{addr[WIN_LSB-1:WAY_LSB+WAY_W], addr[2]};
endmodule

// File: rtl/tagwin_store.sv
module tagwin_store
  import tagwin_pkg::*;
#(
  parameter bit OPERAND = 1'b1,
  parameter int IDX_W   = 8,
  parameter int WAYS    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [$clog2(WAYS)-1:0] rd_way,
  output line_t                   rd_line,
  input  logic                    we,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [$clog2(WAYS)-1:0] wr_way,
  input  line_t                   wr_line
);
  localparam int SETS = 1 << IDX_W;

  line_t way_rd [WAYS];
  line_t fixed;

  // Dirty survives only where kept and only with valid set
  always_comb begin
    fixed   = wr_line;
    fixed.u = OPERAND && wr_line.u && wr_line.v;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    line_t mem [SETS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < SETS; i++) mem[i] <= '0;
      end else if (we && wr_way == w) begin
        mem[wr_idx] <= fixed;
      end
    end

    assign way_rd[w] = mem[rd_idx];

    // R8: a stored invalid line never keeps its dirty bit
    a_r8_v_clears_u: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_way == w && !wr_line.v) |=> !mem[$past(wr_idx)].u);
  end

  assign rd_line = way_rd[rd_way];
endmodule

// File: rtl/tagwin_ctrl.sv
module tagwin_ctrl
  import tagwin_pkg::*;
#(
  parameter bit OPERAND = 1'b1,
  parameter int IDX_W   = 8,
  parameter int WAY_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              dec_bad,
  input  logic              dec_assoc,
  input  logic [IDX_W-1:0]  dec_idx,
  input  logic [WAY_W-1:0]  dec_way,
  input  line_t             cur_line,
  output logic [IDX_W-1:0]  op_idx,
  output logic [WAY_W-1:0]  op_way,
  output logic              we,
  output line_t             wr_line,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              wb_req,
  input  logic              wb_ack,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [IDX_W-1:0]  wb_index,
  output logic [WAY_W-1:0]  wb_way
);
  tw_state_e         st;
  logic              op_wr, op_assoc, op_bad;
  logic [DATA_W-1:0] op_wdata;
  logic              need_wb;

  assign req_ready = (st == ST_IDLE);
  assign need_wb   = OPERAND && cur_line.u && cur_line.v;
  assign wr_line   = word_to_line(op_wdata);
  assign we        = (st == ST_EXEC && op_wr && !op_bad && !op_assoc && !need_wb)
                  || (st == ST_WBWAIT && wb_ack);
  assign wb_req    = (st == ST_WBWAIT);
  assign wb_tag    = TAG_W'(cur_line.tag);
  assign wb_index  = op_idx;
  assign wb_way    = op_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op_wr     <= 1'b0;
      op_assoc  <= 1'b0;
      op_bad    <= 1'b0;
      op_idx    <= '0;
      op_way    <= '0;
      op_wdata  <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          op_wr    <= req_write;
          op_assoc <= dec_assoc;
          op_bad   <= dec_bad;
          op_idx   <= dec_idx;
          op_way   <= dec_way;
          op_wdata <= req_wdata;
          st       <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op_wr && !op_bad && !op_assoc && need_wb) begin
            st <= ST_WBWAIT;
          end else begin
            rsp_valid <= 1'b1;
            rsp_err   <= op_bad;
            rsp_rdata <= (op_bad || op_wr) ? '0 : line_to_word(cur_line);
            st        <= ST_IDLE;
          end
        end
        ST_WBWAIT: if (wb_ack) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_rdata <= '0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: the write-back request and its fields hold until acknowledged
  a_r10_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_tag) && $stable(wb_index) && $stable(wb_way)));
  // R10: the bus stays blocked while a write-back is outstanding
  a_r10_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (!req_ready && !rsp_valid));
  // R12: a response lasts one cycle
  a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/tag_window_port.sv
module tag_window_port
  import tagwin_pkg::*;
#(
  parameter bit OPERAND = 1'b1,
  parameter int IDX_W   = 8,
  parameter int WAYS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        req_size,
  input  logic              req_fetch,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              wb_req,
  input  logic              wb_ack,
  output logic [21:0]       wb_tag,
  output logic [IDX_W-1:0]  wb_index,
  output logic [$clog2(WAYS)-1:0] wb_way
);
  localparam int WAY_W = $clog2(WAYS);

  logic             dec_bad, dec_assoc;
  logic [IDX_W-1:0] dec_idx, op_idx;
  logic [WAY_W-1:0] dec_way, op_way;
  logic             we;
  line_t            cur_line, wr_line;

  tagwin_decode #(.OPERAND(OPERAND), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_dec (
    .addr(req_addr), .size(req_size), .fetch(req_fetch),
    .bad(dec_bad), .assoc(dec_assoc), .idx(dec_idx), .way(dec_way)
  );

  tagwin_store #(.OPERAND(OPERAND), .IDX_W(IDX_W), .WAYS(WAYS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(op_idx), .rd_way(op_way), .rd_line(cur_line),
    .we(we), .wr_idx(op_idx), .wr_way(op_way), .wr_line(wr_line)
  );

  tagwin_ctrl #(.OPERAND(OPERAND), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wdata(req_wdata),
    .dec_bad(dec_bad), .dec_assoc(dec_assoc), .dec_idx(dec_idx), .dec_way(dec_way),
    .cur_line(cur_line), .op_idx(op_idx), .op_way(op_way),
    .we(we), .wr_line(wr_line),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .wb_req(wb_req), .wb_ack(wb_ack), .wb_tag(wb_tag),
    .wb_index(wb_index), .wb_way(wb_way)
  );

  // R2: a wrongly sized access is answered with an error
  a_r2_size_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != SIZE_WORD) |=> ##1 (rsp_valid && rsp_err));

  if (!OPERAND) begin : g_icache_chk
    // R9: the instruction variant never asks for a write-back
    a_r9_no_wb: assert property (@(posedge clk) disable iff (!rst_n) !wb_req);
  end
endmodule

// File: tb/sim_tag_window_port.sv
module sim_tag_window_port;
  // 125 MHz: 8 time-unit period, units taken as ns
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, fetch = 1'b0, ack = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0]  size = 2'b10;

  logic        rdy0, rdy1, rv0, rv1, er0, er1, wb0, wb1;
  logic [31:0] rd0, rd1;
  logic [21:0] wt0, wt1;
  logic [7:0]  wi0, wi1;
  logic [1:0]  ww0, ww1;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] OB = 32'hF080_0000;
  localparam logic [31:0] IB = 32'hF000_0000;

  tag_window_port #(.OPERAND(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(valid && !sel), .req_ready(rdy0),
    .req_addr(addr), .req_write(wr), .req_wdata(wdata), .req_size(size), .req_fetch(fetch),
    .rsp_valid(rv0), .rsp_rdata(rd0), .rsp_err(er0),
    .wb_req(wb0), .wb_ack(ack), .wb_tag(wt0), .wb_index(wi0), .wb_way(ww0));

  tag_window_port #(.OPERAND(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(valid && sel), .req_ready(rdy1),
    .req_addr(addr), .req_write(wr), .req_wdata(wdata), .req_size(size), .req_fetch(fetch),
    .rsp_valid(rv1), .rsp_rdata(rd1), .rsp_err(er1),
    .wb_req(wb1), .wb_ack(ack), .wb_tag(wt1), .wb_index(wi1), .wb_way(ww1));

  wire        ready = sel ? rdy1 : rdy0;
  wire        rvld  = sel ? rv1 : rv0;
  wire [31:0] rdat  = sel ? rd1 : rd0;
  wire        rerr  = sel ? er1 : er0;
  wire        wbq   = sel ? wb1 : wb0;

  function automatic logic [31:0] mk(input logic [31:0] base, input int idx, input int way, input bit a);
    return base | (32'(way) << 12) | (32'(idx) << 4) | (32'(a) << 3);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit s, input logic [31:0] a, input bit w, input logic [31:0] d,
                        input logic [1:0] sz, input bit f,
                        output logic [31:0] rdv, output logic erv);
    int n;
    bit wbseen;
    @(negedge clk);
    sel = s; addr = a; wr = w; wdata = d; size = sz; fetch = f; valid = 1'b1;
    n = 0;
    while (!ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    valid = 1'b0;
    n = 0; wbseen = 0;
    while (!rvld && n < 50) begin
      if (wbq) wbseen = 1;
      @(negedge clk); n++;
    end
    rdv = rdat; erv = rerr;
    chk("R12 response arrives", 32'(n < 50), 32'd1);
    chk("R10 no write-back on plain access", 32'(wbseen), 32'd0);
  endtask

  task automatic rd_line(input bit s, input logic [31:0] a, input string req, input logic [31:0] exp);
    logic [31:0] v; logic e;
    access(s, a, 1'b0, 32'h0, 2'b10, 1'b0, v, e);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    chk("R12 ready after reset", 32'(rdy0), 32'd1);
    chk("R12 no response after reset", 32'(rv0), 32'd0);
    chk("R12 no write-back after reset", 32'(wb0), 32'd0);
    rd_line(0, mk(OB, 5, 2, 0), "R12 entry cleared", 32'h0);
  endtask

  task automatic t_write_read();
    logic [31:0] v; logic e;
    access(0, mk(OB, 8'h3C, 1, 0), 1, 32'hFFFF_FEAD, 2'b10, 0, v, e);
    chk("R7 write no error", 32'(e), 32'd0);
    rd_line(0, mk(OB, 8'h3C, 1, 0), "R7 R6 readback", 32'h1FFF_FEA1);
    rd_line(0, mk(OB, 8'h3C, 1, 1), "R5 read ignores A", 32'h1FFF_FEA1);
    rd_line(0, mk(OB, 8'h3C, 0, 0), "R4 other way untouched", 32'h0);
    rd_line(0, mk(OB, 8'h3D, 1, 0), "R4 other set untouched", 32'h0);
  endtask

  task automatic t_errors();
    logic [31:0] v; logic e;
    access(0, mk(OB, 8'h3C, 1, 0), 1, 32'h1234_5671, 2'b01, 0, v, e);
    chk("R2 half-word rejected", 32'(e), 32'd1);
    access(0, mk(OB, 8'h3C, 1, 0) | 32'h2, 1, 32'h1234_5671, 2'b10, 0, v, e);
    chk("R2 misaligned rejected", 32'(e), 32'd1);
    access(0, mk(OB, 8'h3C, 1, 0) | 32'h0100_0000, 1, 32'h1234_5671, 2'b10, 0, v, e);
    chk("R1 outside window rejected", 32'(e), 32'd1);
    access(0, mk(IB, 8'h3C, 1, 0), 1, 32'h1234_5671, 2'b10, 0, v, e);
    chk("R1 other cache window rejected", 32'(e), 32'd1);
    access(0, mk(OB, 8'h3C, 1, 0), 0, 32'h0, 2'b10, 1, v, e);
    chk("R3 fetch rejected", 32'(e), 32'd1);
    rd_line(0, mk(OB, 8'h3C, 1, 0), "R1 R2 R3 entry unchanged", 32'h1FFF_FEA1);
  endtask

  task automatic t_assoc();
    logic [31:0] v; logic e;
    access(0, mk(OB, 8'h3C, 1, 1), 1, 32'h0000_0401, 2'b10, 0, v, e);
    chk("R11 associative write no error", 32'(e), 32'd0);
    rd_line(0, mk(OB, 8'h3C, 1, 0), "R11 entry unchanged", 32'h1FFF_FEA1);
  endtask

  task automatic t_vclear();
    logic [31:0] v; logic e;
    access(0, mk(OB, 7, 3, 0), 1, 32'h0000_1012, 2'b10, 0, v, e);
    rd_line(0, mk(OB, 7, 3, 0), "R8 dirty dropped with valid=0", 32'h0000_1010);
    access(0, mk(OB, 7, 3, 0), 1, 32'h0000_1013, 2'b10, 0, v, e);
    rd_line(0, mk(OB, 7, 3, 0), "R7 dirty valid stored", 32'h0000_1013);
  endtask

  task automatic t_writeback();
    @(negedge clk);
    chk("R12 ready before stalled write", 32'(rdy0), 32'd1);
    sel = 0; addr = mk(OB, 7, 3, 0); wr = 1; wdata = 32'hABCD_0401; size = 2'b10; fetch = 0; valid = 1;
    @(negedge clk);
    valid = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 wb_req held", 32'(wb0), 32'd1);
      chk("R10 bus blocked", 32'({rdy0, rv0}), 32'd0);
    end
    chk("R10 wb tag", 32'(wt0), 32'h4);
    chk("R10 wb set", 32'(wi0), 32'h7);
    chk("R10 wb way", 32'(ww0), 32'h3);
    ack = 1;
    @(negedge clk);
    ack = 0;
    chk("R10 response after ack", 32'({rv0, er0}), 32'b10);
    chk("R10 wb_req dropped", 32'(wb0), 32'd0);
    rd_line(0, mk(OB, 7, 3, 0), "R10 R6 new fields stored", 32'h0BCD_0401);
  endtask

  task automatic t_icache();
    logic [31:0] v; logic e;
    access(1, mk(IB, 2, 0, 0), 1, 32'h0000_0C03, 2'b10, 0, v, e);
    rd_line(1, mk(IB, 2, 0, 0), "R9 dirty reads zero", 32'h0000_0C01);
    access(1, mk(IB, 2, 0, 0), 1, 32'h0000_0C03, 2'b10, 0, v, e);
    chk("R9 rewrite not stalled", 32'(e), 32'd0);
    access(1, mk(OB, 2, 0, 0), 1, 32'h0000_0C03, 2'b10, 0, v, e);
    chk("R1 operand window rejected by instruction variant", 32'(e), 32'd1);
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_errors();
    t_assoc();
    t_vclear();
    t_writeback();
    t_icache();
    report();
  end
endmodule